// File: doc/BRIEF.md
# Tiny 8-bit Control Sequencer

This block is a very small programmable sequencer that steers an external datapath through an 8-bit control port. Its instructions come from an internal 256-word program memory. Changing what the block does means writing new words into that memory, not changing hardware. Every datum, register, address and output is 8 bits wide.

The block has one add/subtract unit. That unit reads an eight-entry register file and, when an instruction selects it, an 8-bit immediate instead of a second register. The last add or subtract leaves a sign flag and a carry flag. Conditional branches test those flags. An output instruction copies a register onto the control port and raises a one-cycle strobe. Each instruction runs in one cycle. In front of execution sits a registered fetch stage, and a taken branch costs one bubble cycle.

In normal use, software holds the block in reset and loads the program through the write port. It then releases reset and lets the program drive `ctl_out` / `ctl_stb`.

Top module: `ctl_proc8`

## Requirements
- R1: While `rst_n` is low, `ctl_out` is 0, `ctl_stb` is 0, the PC is 0, and every register and both flags are 0. After release, the word at address 0 executes on the second rising edge.
- R2: A word written with `pm_we` at `pm_waddr` is the instruction later fetched from that address. Rewriting a word while reset is held changes the next run's behaviour.
- R3: The instruction word is 16 bits: [15:12] opcode, [11:9] destination register, [8] immediate select, [7:0] source field. With [8]=1 the operand is [7:0]. With [8]=0 the operand is register [2:0] of the source field.
- R4: LD (opcode 1) writes the operand to the destination register and leaves both flags unchanged.
- R5: ADD (opcode 2) writes the 8-bit wrapped sum of destination and operand. Carry becomes the carry-out of the 8-bit addition and sign becomes bit 7 of the result.
- R6: SUB (opcode 3) writes destination minus operand, modulo 256. Carry becomes 1 exactly when the operand is larger than the destination (unsigned borrow), and sign becomes bit 7 of the result.
- R7: OUT (opcode 4) places the destination register on `ctl_out` and raises `ctl_stb` for one cycle per OUT executed. `ctl_out` does not change while `ctl_stb` is low.
- R8: JMP (opcode 5) continues at the address in [7:0]. The word that follows the JMP has no effect. The target executes two cycles after the JMP.
- R9: BRS (opcode 6) and BRC (opcode 7) behave like JMP when the sign flag (BRS) or carry flag (BRC) is 1. Otherwise execution goes on at the next address with no lost cycle.
- R10: Without a taken branch the PC rises by one per cycle and wraps from 255 to 0.
- R11: Opcode 0 and opcodes 8 to 15 change no register, no flag, no output and no sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_we | input | 1 | Program memory write enable |
| pm_waddr | input | 8 | Program memory write address |
| pm_wdata | input | 16 | Program memory write word |
| ctl_out | output | 8 | Control value for the external datapath |
| ctl_stb | output | 1 | One-cycle strobe marking a new `ctl_out` value |

## Verification
The bench counts rising edges after reset is released and checks each result at the cycle it is due:
- An OUT at address k on a straight-line path strobes in cycle k+2.
- Back-to-back OUTs strobe in consecutive cycles.
- A not-taken branch adds no delay.
- A taken branch target executes two cycles after the branch.

All outputs are sampled on falling edges, and every strobe is logged with its cycle number. The expected cycle numbers and values are worked out in the bench from the rules above and compared with that log. Flags are made visible by programs that branch on them and emit a code through OUT.

// File: rtl/ctl_proc8.sv
module ctl_proc8 #(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 8,
  parameter int IW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pm_we,
  input  logic [AW-1:0] pm_waddr,
  input  logic [IW-1:0] pm_wdata,
  output logic [DW-1:0] ctl_out,
  output logic          ctl_stb
);
  localparam int RW    = $clog2(NREG);
  localparam int OPW   = IW - RW - 1 - DW;
  localparam int DEPTH = 1 << AW;

  localparam logic [OPW-1:0] OP_LD  = OPW'(1);
  localparam logic [OPW-1:0] OP_ADD = OPW'(2);
  localparam logic [OPW-1:0] OP_SUB = OPW'(3);
  localparam logic [OPW-1:0] OP_OUT = OPW'(4);
  localparam logic [OPW-1:0] OP_JMP = OPW'(5);
  localparam logic [OPW-1:0] OP_BRS = OPW'(6);
  localparam logic [OPW-1:0] OP_BRC = OPW'(7);

  logic [IW-1:0] pmem [DEPTH];
  logic [AW-1:0] pc;
  logic [IW-1:0] ir;
  logic          iv;
  logic [DW-1:0] rf [NREG];
  logic          sf, cf;

  logic [OPW-1:0] op;
  logic [RW-1:0]  rd;
  logic           isel;
  logic [DW-1:0]  fld, opnd, res;
  logic           co, taken, is_arith, wr_en;

  assign op       = ir[IW-1 -: OPW];
  assign rd       = ir[DW+RW : DW+1];
  assign isel     = ir[DW];
  assign fld      = ir[DW-1:0];
  assign opnd     = isel ? fld : rf[fld[RW-1:0]];
  assign is_arith = iv && (op == OP_ADD || op == OP_SUB);
  assign wr_en    = is_arith || (iv && op == OP_LD);
  assign {co, res} = (op == OP_SUB) ? ({1'b0, rf[rd]} - {1'b0, opnd})
                                    : ({1'b0, rf[rd]} + {1'b0, opnd});
  assign taken = iv && (op == OP_JMP || (op == OP_BRS && sf) || (op == OP_BRC && cf));

  always_ff @(posedge clk)
    if (pm_we) pmem[pm_waddr] <= pm_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc <= '0;
      ir <= '0;
      iv <= 1'b0;
    end else begin
      ir <= pmem[pc];
      if (taken) begin
        pc <= fld[AW-1:0];
        iv <= 1'b0;
      end else begin
        pc <= pc + AW'(1);
        iv <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      sf <= 1'b0;
      cf <= 1'b0;
    end else begin
      if (wr_en) rf[rd] <= (op == OP_LD) ? opnd : res;
      if (is_arith) begin
        sf <= res[DW-1];
        cf <= co;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_out <= '0;
      ctl_stb <= 1'b0;
    end else begin
      ctl_stb <= iv && op == OP_OUT;
      if (iv && op == OP_OUT) ctl_out <= rf[rd];
    end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (pc == '0 && !iv && !ctl_stb && ctl_out == '0 && !sf && !cf));

  p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> (pc == $past(pc) + AW'(1)) && iv);

  p_branch_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (pc == $past(fld[AW-1:0])) && !iv);

  p_stb_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stb |-> $past(iv && op == OP_OUT));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_stb |-> $stable(ctl_out));

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !is_arith |=> $stable({sf, cf}));
endmodule

// File: tb/tb_ctl_proc8.sv
module tb_ctl_proc8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        pm_we = 1'b0;
  logic [7:0]  pm_waddr = '0;
  logic [15:0] pm_wdata = '0;
  logic [7:0]  ctl_out;
  logic        ctl_stb;

  ctl_proc8 dut (.clk, .rst_n, .pm_we, .pm_waddr, .pm_wdata, .ctl_out, .ctl_stb);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, nstb = 0;
  int vals [16];
  int cycs [16];
  bit done = 1'b0;

  always @(negedge clk)
    if (rst_n) begin
      cyc = cyc + 1;
      if (ctl_stb && nstb < 16) begin
        vals[nstb] = int'(ctl_out);
        cycs[nstb] = cyc;
        nstb = nstb + 1;
      end
    end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] I(input int op, input int rd, input int im, input int src);
    return {4'(op), 3'(rd), 1'(im), 8'(src)};
  endfunction

  task automatic wr(input int a, input logic [15:0] w);
    @(negedge clk);
    pm_we = 1'b1; pm_waddr = 8'(a); pm_wdata = w;
    @(negedge clk);
    pm_we = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    #1;
    nstb = 0; cyc = 0;
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
    #1;
    rst_n = 1'b0;
  endtask

  // {sub, a, b}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h10, 8'h20}, {1'b0, 8'hF0, 8'h20}, {1'b0, 8'h70, 8'h10}, {1'b0, 8'hFF, 8'h01},
    {1'b1, 8'h30, 8'h10}, {1'b1, 8'h10, 8'h30}, {1'b1, 8'h80, 8'h01}, {1'b1, 8'h05, 8'h05}};

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ctl_out in reset", int'(ctl_out), 0);
    chk("R1 ctl_stb in reset", int'(ctl_stb), 0);

    for (int i = 0; i < 8; i++) begin
      logic [8:0] full;
      logic [7:0] r;
      int code;
      full = VEC[i][16] ? ({1'b0, VEC[i][15:8]} - {1'b0, VEC[i][7:0]})
                        : ({1'b0, VEC[i][15:8]} + {1'b0, VEC[i][7:0]});
      r = full[7:0];
      code = (full[8] ? 1 : 0) + (r[7] ? 2 : 0);
      wr(0, I(1, 1, 1, VEC[i][15:8]));
      wr(1, I(1, 2, 1, VEC[i][7:0]));
      wr(2, I(VEC[i][16] ? 3 : 2, 1, 0, 2));
      wr(3, I(4, 1, 0, 0));
      wr(4, I(1, 3, 1, 0));
      wr(5, I(7, 0, 1, 7));
      wr(6, I(5, 0, 1, 8));
      wr(7, I(1, 3, 1, 1));
      wr(8, I(6, 0, 1, 10));
      wr(9, I(5, 0, 1, 11));
      wr(10, I(2, 3, 1, 2));
      wr(11, I(4, 3, 0, 0));
      wr(12, I(5, 0, 1, 12));
      run(40);
      chk("R3 strobe count", nstb, 2);
      chk(VEC[i][16] ? "R6 difference" : "R5 sum", vals[0], int'(r));
      chk(VEC[i][16] ? "R6 flags after LD (R4)" : "R5 flags after LD (R4)", vals[1], code);
    end

    // R1 register reset and first-instruction timing; R10 step; R7 back-to-back
    wr(0, I(4, 5, 0, 0));
    wr(1, I(1, 5, 1, 3));
    wr(2, I(4, 5, 0, 0));
    wr(3, I(4, 5, 0, 0));
    wr(4, I(5, 0, 1, 4));
    run(20);
    chk("R7 strobe count", nstb, 3);
    chk("R1 register reset value", vals[0], 0);
    chk("R1 first instruction cycle", cycs[0], 2);
    chk("R10 straight-line cycle", cycs[1], 4);
    chk("R7 back-to-back strobe cycle", cycs[2], 5);
    chk("R7 value", vals[2], 3);

    // R8 jump skips following word, target two cycles later
    wr(0, I(4, 0, 0, 0));
    wr(1, I(5, 0, 1, 5));
    wr(2, I(1, 4, 1, 8'h55));
    wr(3, I(4, 4, 0, 0));
    wr(5, I(4, 4, 0, 0));
    wr(6, I(5, 0, 1, 6));
    run(20);
    chk("R8 strobe count", nstb, 2);
    chk("R8 skipped word no effect", vals[1], 0);
    chk("R8 target cycle", cycs[1], 5);

    // R9 branches not taken, no lost cycle
    wr(0, I(1, 1, 1, 1));
    wr(1, I(6, 0, 1, 9));
    wr(2, I(7, 0, 1, 9));
    wr(3, I(4, 1, 0, 0));
    wr(4, I(5, 0, 1, 4));
    wr(9, I(1, 1, 1, 8'hEE));
    wr(10, I(4, 1, 0, 0));
    wr(11, I(5, 0, 1, 11));
    run(20);
    chk("R9 not taken value", vals[0], 1);
    chk("R9 not taken cycle", cycs[0], 5);

    // R10 wrap 255 -> 0
    wr(0, I(6, 0, 1, 10));
    wr(1, I(5, 0, 1, 254));
    wr(254, I(2, 1, 1, 8'h80));
    wr(255, I(4, 1, 0, 0));
    wr(10, I(2, 1, 1, 1));
    wr(11, I(4, 1, 0, 0));
    wr(12, I(5, 0, 1, 12));
    run(30);
    chk("R10 wrap count", nstb, 2);
    chk("R10 before wrap", vals[0], 8'h80);
    chk("R10 after wrap (R9 BRS taken)", vals[1], 8'h81);

    // R11 undefined opcodes
    wr(0, I(1, 1, 1, 5));
    wr(1, I(15, 1, 1, 8'hFF));
    wr(2, I(8, 1, 0, 1));
    wr(3, I(4, 1, 0, 0));
    wr(4, I(5, 0, 1, 4));
    run(20);
    chk("R11 strobe count", nstb, 1);
    chk("R11 register unchanged", vals[0], 5);
    chk("R11 no sequencing change", cycs[0], 5);

    // R2 rewrite one word
    wr(0, I(1, 1, 1, 8'h3C));
    run(20);
    chk("R2 rewritten program", vals[0], 8'h3C);
    #1;
    chk("R1 ctl_out cleared by reset", int'(ctl_out), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule